// File: doc/BRIEF.md
# Transaction Error Flags and Fault Alarm

This block sits behind the frame receiver of a serial position-encoder link. During one request/response transaction the receiver raises single-cycle strobes for the faults it detects. The encoder may also report, through its status field, that the request it received was corrupted. The block gathers all of these into a six-bit error register. Each bit keeps a fixed meaning, so firmware or downstream logic can tell what went wrong in the last transaction. The register clears itself when the next transaction is launched.

Alongside the register, the block counts faulty transactions in a saturating counter. A transaction adds at most one to the count, however many faults it shows. Once the count rises above the parameter `THRESH`, a sticky alarm is raised. The alarm stays up until a one-cycle clear pulse arrives, and that pulse also zeroes the count. The reset is asynchronous and active low.

Top module: `fault_monitor`

## Requirements
- R1: While `rst_n` is low, `err_o` is 0 and `alarm_o` is 0.
- R2: Each receiver strobe sets its own error bit on the clock edge where it is sampled: `cf_par_err` sets bit 0, `start_seq_err` bit 1, `timeout_err` bit 2 and `crc_err` bit 3. Set bits accumulate and stay set until the next transaction start.
- R3: When `status_vld` is high, `status_flags[0]` (status field bit 6, transmit parity) sets error bit 4 and `status_flags[1]` (status field bit 7, transmit delimiter) sets error bit 5. When `status_vld` is low, `status_flags` has no effect.
- R4: A `txn_start` pulse clears every bit that earlier cycles set. Strobes sampled in the same cycle as `txn_start` belong to the new transaction and are kept.
- R5: The fault count goes up by at most one per transaction, on that transaction's first error. Further errors in the same transaction do not add to it.
- R6: `alarm_o` rises one cycle after the count first exceeds `THRESH`, which happens on the (THRESH+1)-th faulty transaction. It does not rise when the count equals `THRESH`.
- R7: Once raised, `alarm_o` stays high through any number of further faulty or clean transactions. The count saturates and does not wrap.
- R8: An `alarm_clear` pulse drops `alarm_o` on the next edge and sets the count to zero, so another THRESH+1 faulty transactions are needed before the alarm returns.
- R9: If `alarm_clear` falls in the same cycle as a transaction's first error, the clear wins: the count ends at zero. The error bit is still recorded in `err_o`.
- R10: Pulling `rst_n` low clears `err_o` and `alarm_o` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| txn_start | input | 1 | One-cycle pulse that opens a new transaction |
| alarm_clear | input | 1 | One-cycle pulse that drops the alarm and zeroes the count |
| cf_par_err | input | 1 | Strobe: parity fault in the received control field |
| start_seq_err | input | 1 | Strobe: start pattern not seen before timeout |
| timeout_err | input | 1 | Strobe: message incomplete, timeout between fields |
| crc_err | input | 1 | Strobe: received CRC differs from the computed CRC |
| status_vld | input | 1 | Status field of the reply has been received this cycle |
| status_flags | input | 2 | Status field bits 7:6 (bit 1 = delimiter, bit 0 = parity fault at the encoder) |
| err_o | output | 6 | Error register of the current transaction |
| alarm_o | output | 1 | Sticky fault alarm |

## Verification
Two collisions matter here. A transaction start can land in the same cycle as an error strobe, and an alarm clear can land in the same cycle as a transaction's first fault. The bench drives the first case as a start pulse carrying a CRC strobe, right after a transaction that left other bits set. It then expects only the CRC bit in the register. For the second case, the bench fires the clear together with a fresh fault while the alarm is up. It checks that the alarm drops, that the fault bit is still shown, and that exactly THRESH+1 further faulty transactions are needed to raise the alarm again. If the colliding fault had been counted, the alarm would come back one transaction early.

// File: rtl/fault_mon_pkg.sv
package fault_mon_pkg;

  // width of the error register
  localparam int ERR_W = 6;

  // bit positions of the error register; fixed, decoded by software
  localparam int B_CF_PAR  = 0;
  localparam int B_START   = 1;
  localparam int B_TIMEOUT = 2;
  localparam int B_CRC     = 3;
  localparam int B_TX_PAR  = 4;
  localparam int B_TX_DLM  = 5;

  // positions inside the two-bit slice taken from status field bits 7:6
  localparam int F_TX_PAR = 0;
  localparam int F_TX_DLM = 1;

  typedef logic [ERR_W-1:0] err_vec_t;

endpackage

// File: rtl/err_collect.sv
module err_collect
  import fault_mon_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           txn_start,
  input  logic           cf_par_err,
  input  logic           start_seq_err,
  input  logic           timeout_err,
  input  logic           crc_err,
  input  logic           status_vld,
  input  logic [1:0]     status_flags,
  output err_vec_t       err_q,
  output logic           first_hit
);

  err_vec_t hits;
  err_vec_t base;
  err_vec_t err_d;

  // map each cause onto its fixed bit
  always_comb begin
    hits            = '0;
    hits[B_CF_PAR]  = cf_par_err;
    hits[B_START]   = start_seq_err;
    hits[B_TIMEOUT] = timeout_err;
    hits[B_CRC]     = crc_err;
    hits[B_TX_PAR]  = status_vld & status_flags[F_TX_PAR];
    hits[B_TX_DLM]  = status_vld & status_flags[F_TX_DLM];
  end

  // a start pulse discards the previous transaction's bits;
  // strobes of the start cycle already belong to the new one
  always_comb begin
    base      = txn_start ? '0 : err_q;
    err_d     = base | hits;
    first_hit = (base == '0) && (hits != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= err_d;
  end

endmodule

// File: rtl/fault_tally.sv
module fault_tally #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt_q
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (clr)                   cnt_q <= '0;
    else if (inc && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/alarm_latch.sv
module alarm_latch #(
  parameter int THRESH = 3,
  parameter int CNT_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] cnt,
  output logic             alarm_q
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(THRESH);

  logic over;
  assign over = cnt > LIMIT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   alarm_q <= 1'b0;
    else if (clr) alarm_q <= 1'b0;
    else if (over) alarm_q <= 1'b1;
  end

endmodule

// File: rtl/fault_monitor.sv
module fault_monitor
  import fault_mon_pkg::*;
#(
  parameter int THRESH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             txn_start,
  input  logic             alarm_clear,
  input  logic             cf_par_err,
  input  logic             start_seq_err,
  input  logic             timeout_err,
  input  logic             crc_err,
  input  logic             status_vld,
  input  logic [1:0]       status_flags,
  output logic [ERR_W-1:0] err_o,
  output logic             alarm_o
);

  // room for THRESH+1 so the count can pass the threshold
  localparam int CNT_W = $clog2(THRESH + 2);

  err_vec_t         err_q;
  logic             first_hit;
  logic [CNT_W-1:0] fault_cnt;

  err_collect u_collect (
    .clk           (clk),
    .rst_n         (rst_n),
    .txn_start     (txn_start),
    .cf_par_err    (cf_par_err),
    .start_seq_err (start_seq_err),
    .timeout_err   (timeout_err),
    .crc_err       (crc_err),
    .status_vld    (status_vld),
    .status_flags  (status_flags),
    .err_q         (err_q),
    .first_hit     (first_hit)
  );

  fault_tally #(.CNT_W(CNT_W)) u_tally (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (first_hit),
    .clr   (alarm_clear),
    .cnt_q (fault_cnt)
  );

  alarm_latch #(.THRESH(THRESH), .CNT_W(CNT_W)) u_alarm (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (alarm_clear),
    .cnt     (fault_cnt),
    .alarm_q (alarm_o)
  );

  assign err_o = err_q;

endmodule

// File: rtl/fault_monitor_chk.sv
module fault_monitor_chk #(
  parameter int THRESH = 3,
  parameter int CNT_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             txn_start,
  input logic             alarm_clear,
  input logic             cf_par_err,
  input logic             start_seq_err,
  input logic             timeout_err,
  input logic             crc_err,
  input logic             status_vld,
  input logic [5:0]       err_o,
  input logic             alarm_o,
  input logic [CNT_W-1:0] cnt_q
);

  logic any_strobe;
  assign any_strobe = cf_par_err | start_seq_err | timeout_err | crc_err | status_vld;

  // R2
  sticky_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !txn_start |=> ((err_o & $past(err_o)) == $past(err_o)));

  // R4
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_start && !any_strobe) |=> (err_o == '0));

  // R5
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_clear |=> ({1'b0, cnt_q} <= {1'b0, $past(cnt_q)} + 1'b1));

  // R6
  alarm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_o) |-> ($past(cnt_q) > CNT_W'(THRESH)));

  // R7
  alarm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_o && !alarm_clear) |=> alarm_o);

  // R8
  clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_clear |=> (!alarm_o && cnt_q == '0));

endmodule

bind fault_monitor fault_monitor_chk #(.THRESH(THRESH), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .txn_start     (txn_start),
  .alarm_clear   (alarm_clear),
  .cf_par_err    (cf_par_err),
  .start_seq_err (start_seq_err),
  .timeout_err   (timeout_err),
  .crc_err       (crc_err),
  .status_vld    (status_vld),
  .err_o         (err_o),
  .alarm_o       (alarm_o),
  .cnt_q         (fault_cnt)
);

// File: tb/test_fault_monitor.sv
module test_fault_monitor;

  localparam int CLK_P  = 10;
  localparam int THRESH = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       txn_start, alarm_clear;
  logic       cf_par_err, start_seq_err, timeout_err, crc_err;
  logic       status_vld;
  logic [1:0] status_flags;
  logic [5:0] err_o;
  logic       alarm_o;

  int total = 0;
  int bad   = 0;

  always #(CLK_P/2) clk = ~clk;

  fault_monitor #(.THRESH(THRESH)) i_fault_monitor (
    .clk           (clk),
    .rst_n         (rst_n),
    .txn_start     (txn_start),
    .alarm_clear   (alarm_clear),
    .cf_par_err    (cf_par_err),
    .start_seq_err (start_seq_err),
    .timeout_err   (timeout_err),
    .crc_err       (crc_err),
    .status_vld    (status_vld),
    .status_flags  (status_flags),
    .err_o         (err_o),
    .alarm_o       (alarm_o)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_err(input string req, input logic [5:0] exp);
    check(err_o === exp, req, int'(err_o), int'(exp));
  endtask

  task automatic chk_alarm(input string req, input logic exp);
    check(alarm_o === exp, req, int'(alarm_o), int'(exp));
  endtask

  // one clock of stimulus; entered and left at a falling edge
  // e = {crc, timeout, start_seq, cf_par}
  task automatic cyc(input logic s, input logic c, input logic [3:0] e,
                     input logic v, input logic [1:0] f);
    txn_start     = s;
    alarm_clear   = c;
    cf_par_err    = e[0];
    start_seq_err = e[1];
    timeout_err   = e[2];
    crc_err       = e[3];
    status_vld    = v;
    status_flags  = f;
    @(negedge clk);
    txn_start = 0; alarm_clear = 0; cf_par_err = 0; start_seq_err = 0;
    timeout_err = 0; crc_err = 0; status_vld = 0; status_flags = 2'b00;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic faulty_txn();
    cyc(1, 0, 4'b1000, 0, 2'b00);
  endtask

  task automatic t_reset();
    chk_err("R1", 6'd0);
    chk_alarm("R1", 1'b0);
  endtask

  task automatic t_bits();
    cyc(1, 0, 4'b0000, 0, 2'b00);
    cyc(0, 0, 4'b0001, 0, 2'b00); chk_err("R2", 6'b000001);
    cyc(0, 0, 4'b1000, 0, 2'b00); chk_err("R2", 6'b001001);
    cyc(0, 0, 4'b0100, 0, 2'b00); chk_err("R2", 6'b001101);
    cyc(0, 0, 4'b0010, 0, 2'b00); chk_err("R2", 6'b001111);
    idle();                        chk_err("R2", 6'b001111);
    cyc(1, 0, 4'b0000, 0, 2'b00); chk_err("R4", 6'b000000);
  endtask

  task automatic t_status();
    cyc(1, 0, 4'b0000, 0, 2'b00);
    cyc(0, 0, 4'b0000, 0, 2'b11); chk_err("R3", 6'b000000);
    cyc(0, 0, 4'b0000, 1, 2'b01); chk_err("R3", 6'b010000);
    cyc(0, 0, 4'b0000, 1, 2'b10); chk_err("R3", 6'b110000);
    cyc(1, 0, 4'b0000, 1, 2'b10); chk_err("R3", 6'b100000);
  endtask

  task automatic t_start_collide();
    cyc(1, 0, 4'b0011, 0, 2'b00);
    cyc(0, 0, 4'b0100, 0, 2'b00); chk_err("R4", 6'b000111);
    cyc(1, 0, 4'b1000, 0, 2'b00); chk_err("R4", 6'b001000);
  endtask

  task automatic t_once_per_txn();
    cyc(0, 1, 4'b0000, 0, 2'b00);
    for (int k = 0; k < THRESH; k++) begin
      cyc(1, 0, 4'b0011, 0, 2'b00);
      cyc(0, 0, 4'b1100, 1, 2'b11);
      cyc(0, 0, 4'b1111, 0, 2'b00);
    end
    idle(); idle();
    chk_alarm("R5", 1'b0);
  endtask

  task automatic t_threshold();
    cyc(0, 1, 4'b0000, 0, 2'b00);
    for (int k = 0; k < THRESH; k++) faulty_txn();
    idle(); idle();
    chk_alarm("R6", 1'b0);
    faulty_txn();
    chk_alarm("R6", 1'b0);
    idle();
    chk_alarm("R6", 1'b1);
  endtask

  task automatic t_sticky();
    for (int k = 0; k < 20; k++) faulty_txn();
    for (int k = 0; k < 4; k++) cyc(1, 0, 4'b0000, 0, 2'b00);
    idle();
    chk_alarm("R7", 1'b1);
    chk_err("R7", 6'b000000);
  endtask

  task automatic t_clear();
    cyc(0, 1, 4'b0000, 0, 2'b00);
    chk_alarm("R8", 1'b0);
    for (int k = 0; k < THRESH; k++) faulty_txn();
    idle(); idle();
    chk_alarm("R8", 1'b0);
    faulty_txn(); idle();
    chk_alarm("R8", 1'b1);
  endtask

  task automatic t_clear_collide();
    cyc(1, 0, 4'b0000, 0, 2'b00);
    cyc(0, 1, 4'b0100, 0, 2'b00);
    chk_alarm("R9", 1'b0);
    chk_err("R9", 6'b000100);
    for (int k = 0; k < THRESH; k++) faulty_txn();
    idle(); idle();
    chk_alarm("R9", 1'b0);
    faulty_txn(); idle();
    chk_alarm("R9", 1'b1);
  endtask

  task automatic t_async_reset();
    cyc(1, 0, 4'b0001, 0, 2'b00);
    #(CLK_P/5);
    rst_n = 1'b0;
    #1;
    chk_err("R10", 6'd0);
    chk_alarm("R10", 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    idle();
    chk_err("R10", 6'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    txn_start = 0; alarm_clear = 0; cf_par_err = 0; start_seq_err = 0;
    timeout_err = 0; crc_err = 0; status_vld = 0; status_flags = 2'b00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle();
    t_bits();
    t_status();
    t_start_collide();
    t_once_per_txn();
    t_threshold();
    t_sticky();
    t_clear();
    t_clear_collide();
    t_async_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule